// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

The arbiter picks one winner from up to 64 local interrupt lines that are already pending and enabled. Each line carries an 8-bit programmed priority. A smaller effective priority wins, and on a tie the lower interrupt number wins. Masking, delegation and privilege filtering happen upstream. The block sees only the final pending vector. It returns a valid flag and the 6-bit number of the winning line.

A programmed priority of zero is not treated as the most urgent value. It is replaced by one of two values, chosen by where the line sits in a fixed built-in default ranking. Lines ranked above the machine-level software/timer/external group get 1. All other lines get 255. A legacy input switches priorities off entirely, and the lowest-numbered pending line then wins. Selection runs through a combinational tournament tree. A parameter adds one output register stage for timing closure; it is on by default.

Top module: `irq_prio_arb`

## Requirements
- R1: With no pending bit set, `win_valid_o` is 0.
- R2: With `legacy_en` = 1, the winner is the lowest-numbered pending line, whatever its priority field holds.
- R3: With `legacy_en` = 0, the pending line with the numerically smallest effective priority wins. A nonzero programmed value is its own effective priority.
- R4: Among pending lines with equal effective priority, the lowest interrupt number wins.
- R5: A programmed priority of 0 on lines 24 to 31 or 48 to 63 is treated as effective priority 1. These are the lines ranked above the machine group in the default order.
- R6: A programmed priority of 0 on any other line (0 to 23, 32 to 47) is treated as effective priority 255.
- R7: When any bit is pending, `win_valid_o` is 1 and the reported line is one of the pending lines.
- R8: With `OUT_REG` = 1, the result appears one clock after the inputs are presented. While `rst_n` is low, both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_en | input | 1 | 1: lowest number wins, priorities ignored |
| pend_i | input | 64 | Pending-and-enabled vector, bit n = line n |
| prio_i | input | 512 | Programmed priorities, line n at bits [8n+7:8n] |
| win_valid_o | output | 1 | A winner exists |
| win_id_o | output | 6 | Number of the winning line |

## Verification
Directed patterns separate the distinct rules. A legacy case uses a high-numbered line with a better priority, which tells index order apart from priority order. Equal-priority pairs show that the tie-break goes to the lower number. Zero-priority lines are placed in the high group and in the low group against programmed values of 1, 2, 254 and 255. This shows both substitution values and their ties. Random pending vectors of dense and sparse density, with priorities drawn from a narrow range rich in zeros and ties and from the full range, are compared against a sequential scan in the bench.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   // Position of a line in the fixed default ranking, 0 = most urgent.
   function automatic int dflt_rank(input int irq);
      int k;
      int r;
      r = 63;
      if (irq >= 48 && irq <= 63) begin
         k = 63 - irq;
         r = (k >> 2) * 6 + (k & 1) + (((k & 2) != 0) ? 4 : 0);
      end else if (irq >= 24 && irq <= 31) begin
         k = 31 - irq;
         r = (k >> 1) * 6 + 2 + (k & 1);
      end else if (irq >= 32 && irq <= 47) begin
         k = 47 - irq;
         r = 34 + (k >> 2) * 6 + (k & 1) + (((k & 2) != 0) ? 4 : 0);
      end else if (irq >= 16 && irq <= 23) begin
         k = 23 - irq;
         r = 34 + (k >> 1) * 6 + 2 + (k & 1);
      end else begin
         case (irq)
            11: r = 24;
            3:  r = 25;
            7:  r = 26;
            9:  r = 27;
            1:  r = 28;
            5:  r = 29;
            12: r = 30;
            10: r = 31;
            2:  r = 32;
            6:  r = 33;
            0:  r = 58;
            4:  r = 59;
            8:  r = 60;
            13: r = 61;
            14: r = 62;
            default: r = 63;
         endcase
      end
      return r;
   endfunction

   // True when the line ranks ahead of the machine-level group (led by 11).
   function automatic bit over_machine(input int irq);
      return dflt_rank(irq) < dflt_rank(11);
   endfunction

endpackage

// File: rtl/irq_eff_prio.sv
module irq_eff_prio #(
   parameter int N  = 64,
   parameter int PW = 8,
   parameter int EW = PW + 1
) (
   input  logic            legacy_en,
   input  logic [N*PW-1:0] prio_i,
   output logic [N*EW-1:0] eff_o
);
   localparam logic [EW-1:0] SUB_HI = EW'(1);
   localparam logic [EW-1:0] SUB_LO = EW'((1 << PW) - 1);

   for (genvar gi = 0; gi < N; gi++) begin : g_lane
      localparam bit HI = irq_prio_pkg::over_machine(gi);
      logic [PW-1:0] raw;
      logic [EW-1:0] eff;
      assign raw = prio_i[gi*PW +: PW];
      always_comb begin
         if (legacy_en)      eff = '0;
         else if (raw == '0) eff = HI ? SUB_HI : SUB_LO;
         else                eff = EW'(raw);
      end
      assign eff_o[gi*EW +: EW] = eff;
   end
endmodule

// File: rtl/irq_win_tree.sv
module irq_win_tree #(
   parameter int N  = 64,
   parameter int EW = 9,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]    pend_i,
   input  logic [N*EW-1:0] eff_i,
   output logic            vld_o,
   output logic [IW-1:0]   id_o
);
   localparam int NODES = 2 * N - 1;
   localparam int LEAF0 = N - 1;

   logic          n_vld [NODES];
   logic [EW-1:0] n_eff [NODES];
   logic [IW-1:0] n_id  [NODES];

   for (genvar gl = 0; gl < N; gl++) begin : g_leaf
      assign n_vld[LEAF0+gl] = pend_i[gl];
      assign n_eff[LEAF0+gl] = eff_i[gl*EW +: EW];
      assign n_id[LEAF0+gl]  = IW'(gl);
   end

   // Left child covers lower numbers; right wins only when strictly better.
   for (genvar gn = 0; gn < N - 1; gn++) begin : g_node
      logic take_r;
      assign take_r = n_vld[2*gn+2] &&
                      (!n_vld[2*gn+1] || (n_eff[2*gn+2] < n_eff[2*gn+1]));
      assign n_vld[gn] = n_vld[2*gn+1] | n_vld[2*gn+2];
      assign n_eff[gn] = take_r ? n_eff[2*gn+2] : n_eff[2*gn+1];
      assign n_id[gn]  = take_r ? n_id[2*gn+2]  : n_id[2*gn+1];
   end

   assign vld_o = n_vld[0];
   assign id_o  = n_id[0];
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int N_IRQ   = 64,
   parameter int PRIO_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      legacy_en,
   input  logic [N_IRQ-1:0]          pend_i,
   input  logic [N_IRQ*PRIO_W-1:0]   prio_i,
   output logic                      win_valid_o,
   output logic [$clog2(N_IRQ)-1:0]  win_id_o
);
   localparam int IW = $clog2(N_IRQ);
   localparam int EW = PRIO_W + 1;

   if ((1 << IW) != N_IRQ || N_IRQ < 2) begin : g_bad_n
      $error("N_IRQ must be a power of two, at least 2");
   end
   if (N_IRQ > 64) begin : g_bad_rank
      $error("default ranking covers at most 64 lines");
   end
   if (PRIO_W < 2) begin : g_bad_pw
      $error("PRIO_W must be at least 2");
   end

   logic [N_IRQ*EW-1:0] eff;
   logic                cmb_vld;
   logic [IW-1:0]       cmb_id;

   irq_eff_prio #(.N(N_IRQ), .PW(PRIO_W), .EW(EW)) u_eff (
      .legacy_en (legacy_en),
      .prio_i    (prio_i),
      .eff_o     (eff)
   );

   irq_win_tree #(.N(N_IRQ), .EW(EW), .IW(IW)) u_tree (
      .pend_i (pend_i),
      .eff_i  (eff),
      .vld_o  (cmb_vld),
      .id_o   (cmb_id)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_valid_o <= 1'b0;
            win_id_o    <= '0;
         end else begin
            win_valid_o <= cmb_vld;
            win_id_o    <= cmb_id;
         end
      end
   end else begin : g_comb
      assign win_valid_o = cmb_vld;
      assign win_id_o    = cmb_id;
   end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
   parameter int N_IRQ   = 64,
   parameter int IW      = 6,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             legacy_en,
   input logic [N_IRQ-1:0] pend,
   input logic             c_vld,
   input logic [IW-1:0]    c_id,
   input logic             o_vld,
   input logic [IW-1:0]    o_id
);
   logic [N_IRQ-1:0] below;
   logic             seen;
   assign below = (N_IRQ'(1) << c_id) - N_IRQ'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   p_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !c_vld);
   p_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> c_vld);
   p_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      c_vld |-> pend[c_id]);
   p_legacy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && c_vld) |-> ((pend & below) == '0));

   if (OUT_REG) begin : g_reg_chk
      p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
         seen |-> (o_vld == $past(c_vld)) && (!o_vld || o_id == $past(c_id)));
   end else begin : g_comb_chk
      p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (o_vld == c_vld) && (!o_vld || o_id == c_id));
   end
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.N_IRQ(N_IRQ), .IW(IW), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .legacy_en (legacy_en),
   .pend      (pend_i),
   .c_vld     (cmb_vld),
   .c_id      (cmb_id),
   .o_vld     (win_valid_o),
   .o_id      (win_id_o)
);

// File: tb/irq_prio_arb_bench.sv
module irq_prio_arb_bench;
   localparam int N  = 64;
   localparam int PW = 8;

   typedef struct {
      logic  vld;
      int    id;
      string req;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            legacy_en = 1'b0;
   logic [N-1:0]    pend = '0;
   logic [N*PW-1:0] prio = '0;
   logic            win_valid_o;
   logic [5:0]      win_id_o;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   irq_prio_arb u_irq_prio_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .legacy_en   (legacy_en),
      .pend_i      (pend),
      .prio_i      (prio),
      .win_valid_o (win_valid_o),
      .win_id_o    (win_id_o)
   );

   function automatic int eff_of(input int id, input logic [7:0] p);
      if (p != 0) return int'(p);
      if ((id >= 24 && id <= 31) || id >= 48) return 1;
      return 255;
   endfunction

   function automatic exp_t ref_pick(input logic lg, input logic [N-1:0] p,
                                     input logic [N*PW-1:0] pr, input string req);
      exp_t e;
      int   best;
      e.vld = 1'b0; e.id = 0; e.req = req; best = 1000;
      for (int i = 0; i < N; i++) begin
         if (p[i]) begin
            int v;
            v = lg ? 0 : eff_of(i, pr[i*PW +: PW]);
            if (v < best) begin best = v; e.id = i; e.vld = 1'b1; end
         end
      end
      return e;
   endfunction

   task automatic drive(input logic lg, input logic [N-1:0] p,
                        input logic [N*PW-1:0] pr, input string req);
      @(negedge clk);
      legacy_en = lg; pend = p; prio = pr;
      sb_q.push_back(ref_pick(lg, p, pr, req));
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Monitor: one registered result per pushed item, sampled after the edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (win_valid_o !== e.vld || (e.vld && win_id_o !== 6'(e.id))) begin
               n_bad++;
               $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                        e.req, win_valid_o, win_id_o, e.vld, e.id);
            end
         end
      end
   end

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      report();
   end

   initial begin
      logic [N*PW-1:0] pv;
      // R8: reset state, with lines pending
      pend = 64'hFF;
      repeat (3) @(negedge clk);
      n_chk++;
      if (win_valid_o !== 1'b0 || win_id_o !== 6'd0) begin
         n_bad++;
         $display("FAIL R8 reset: got valid=%0b id=%0d, expected valid=0 id=0",
                  win_valid_o, win_id_o);
      end
      rst_n = 1'b1;

      // R1: nothing pending
      drive(1'b0, '0, '0, "R1");
      drive(1'b1, '0, '0, "R1 legacy");
      // R2: legacy ignores the better priority of line 9
      pv = '0; pv[5*8 +: 8] = 8'd200; pv[9*8 +: 8] = 8'd1;
      drive(1'b1, (64'd1 << 5) | (64'd1 << 9), pv, "R2");
      drive(1'b0, (64'd1 << 5) | (64'd1 << 9), pv, "R3 same inputs, legacy off");
      // R3: smaller priority wins
      pv = '0; pv[5*8 +: 8] = 8'd10; pv[40*8 +: 8] = 8'd3;
      drive(1'b0, (64'd1 << 5) | (64'd1 << 40), pv, "R3");
      // R4: tie goes to lower number
      pv = '0; pv[7*8 +: 8] = 8'd50; pv[20*8 +: 8] = 8'd50;
      drive(1'b0, (64'd1 << 7) | (64'd1 << 20), pv, "R4");
      // R5: zero on line 60 becomes 1, beats 2
      pv = '0; pv[2*8 +: 8] = 8'd2;
      drive(1'b0, (64'd1 << 2) | (64'd1 << 60), pv, "R5");
      // R5: zero on line 30 ties with programmed 1 on line 10, lower wins
      pv = '0; pv[10*8 +: 8] = 8'd1;
      drive(1'b0, (64'd1 << 10) | (64'd1 << 30), pv, "R5 tie");
      // R6: zero on line 3 becomes 255, loses to 254
      pv = '0; pv[17*8 +: 8] = 8'd254;
      drive(1'b0, (64'd1 << 3) | (64'd1 << 17), pv, "R6");
      // R6: zero on line 3 ties with 255 on line 40, lower wins
      pv = '0; pv[40*8 +: 8] = 8'd255;
      drive(1'b0, (64'd1 << 3) | (64'd1 << 40), pv, "R6 tie");
      // R7: single top line
      drive(1'b0, 64'd1 << 63, '0, "R7 single");

      // R3/R4/R7: random dense and sparse vectors, narrow and full priorities
      for (int t = 0; t < 400; t++) begin
         logic [N-1:0] p;
         p = {$urandom(), $urandom()};
         if (t % 2 == 0) p = p & {$urandom(), $urandom()} & {$urandom(), $urandom()};
         for (int i = 0; i < N; i++)
            pv[i*8 +: 8] = (t % 3 == 0) ? 8'($urandom()) : 8'($urandom() % 4);
         drive((t % 7 == 0), p, pv, "R3/R4/R7 random");
      end

      @(negedge clk);
      wait (sb_q.size() == 0);
      @(negedge clk);
      report();
   end
endmodule